// File: doc/BRIEF.md
# Configuration Image Header Parser

This block sits in front of a device-programming engine. A configuration image arrives one byte per cycle on a valid/ready input. The parser strips the image's header and passes only the configuration payload downstream. The header has four parts, in this order:

- a fixed 13-byte signature;
- four descriptive text sections (name, part, date, time), each made of a tag byte, a 16-bit big-endian length and that many text bytes;
- an end tag;
- a 32-bit big-endian payload length.

After the header, every payload byte goes straight through to the output under the consumer's backpressure. The parser counts these bytes against the parsed length. When the count runs out, it signals completion with a one-cycle pulse.

A signature mismatch or a wrong end tag stops the parser for good. It raises an error flag and refuses further input until a synchronous reset. A parameter chooses what happens to the text bytes: they are either discarded silently or presented on a side output, together with the index of the section they belong to.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, and `hdr_error`, `done`, `len_valid`, `out_valid`, `info_valid` and `pay_len` are all 0.
- R2: The first 13 accepted bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01, in that order. A mismatch at any position sets `hdr_error` from the next cycle. `hdr_error` then stays set and `in_ready` stays 0 until reset, whatever the input does.
- R3: After the signature come four sections. Each is one tag byte (any value), a length high byte, a length low byte, and then that many text bytes. While a text byte is offered, `info_valid` equals `in_valid`, `info_data` equals `in_data`, and `info_field` holds the section index, 0 to 3 in arrival order.
- R4: A section whose length is 0 has no text bytes. The byte that follows its length is the next tag.
- R5: The byte after the fourth section must be 0x65. Any other value sets `hdr_error`, with the same sticky behaviour as R2.
- R6: The four bytes after the end tag form `pay_len`, most significant byte first. From the cycle after the last of these bytes is accepted, `len_valid` is 1 and `pay_len` holds that value, both unchanged until reset.
- R7: During the payload, `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`. No byte is accepted or forwarded while `out_ready` is 0.
- R8: `done` is 1 for exactly one cycle. That cycle follows the acceptance of the last payload byte, or of the last length byte when `pay_len` is 0. From then on, `in_ready` is 0 until reset.
- R9: With the parameter `EXPOSE_INFO` set to 0, `info_valid` is never 1. Parsing and payload forwarding are unchanged.
- R10: Outside the text sections, `info_valid` is 0. Outside the payload, `out_valid` is 0. Header bytes never reach the payload output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Parser accepts the input byte this cycle |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream accepts the payload byte |
| info_valid | output | 1 | Text byte of a header section is present |
| info_data | output | 8 | Text byte |
| info_field | output | 2 | Index of the section the text byte belongs to |
| hdr_error | output | 1 | Sticky header error |
| done | output | 1 | One-cycle completion pulse |
| len_valid | output | 1 | `pay_len` holds the parsed length |
| pay_len | output | 32 | Parsed payload length |

## Verification
Almost every internal mistake changes which bytes the parser believes are header and which are payload, so it shows up within one byte at the ports. Two examples:

- A wrong signature index or section counter makes a text byte appear on the payload output, or a payload byte on the text output, in the same cycle that byte is offered.
- A wrong length-byte order or countdown makes `pay_len` differ, or moves `done`, on the cycle after the final length byte or payload byte.

The bench therefore compares the classification of every byte in a complete image, cycle by cycle. Directed cases cover stalls, zero lengths and both error points.

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser #(
  parameter bit          EXPOSE_INFO = 1'b1,
  parameter int          NUM_INFO    = 4,
  parameter logic [7:0]  END_TAG     = 8'h65
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [7:0]                  in_data,
  output logic                        in_ready,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  input  logic                        out_ready,
  output logic                        info_valid,
  output logic [7:0]                  info_data,
  output logic [$clog2(NUM_INFO)-1:0] info_field,
  output logic                        hdr_error,
  output logic                        done,
  output logic                        len_valid,
  output logic [31:0]                 pay_len
);
  localparam int PRE_LEN   = 13;
  localparam int LEN_BYTES = 4;
  localparam int FLD_W     = $clog2(NUM_INFO);

  typedef enum logic [3:0] {
    S_PRE, S_TAG, S_LHI, S_LLO, S_BODY, S_ETAG, S_PLEN, S_PAY, S_FIN, S_ERR
  } state_t;

  state_t      state;
  logic [3:0]  idx;
  logic [FLD_W-1:0] fld;
  logic [7:0]  sec_hi;
  logic [15:0] sec_cnt;
  logic [23:0] len_sh;
  logic [31:0] rem;
  logic [31:0] len_q;
  logic        len_ok_q, err_q, done_q;

  function automatic logic [7:0] pre_byte(input logic [3:0] i);
    case (i)
      4'd0, 4'd10, 4'd11: pre_byte = 8'h00;
      4'd1:               pre_byte = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8: pre_byte = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9: pre_byte = 8'hF0;
      4'd12:              pre_byte = 8'h01;
      default:            pre_byte = 8'h00;
    endcase
  endfunction

  wire        fire     = in_valid && in_ready;
  wire        last_fld = (fld == FLD_W'(NUM_INFO - 1));
  wire [31:0] len_full = {len_sh, in_data};
  wire [15:0] sec_len  = {sec_hi, in_data};

  assign in_ready   = (state != S_FIN) && (state != S_ERR) && ((state != S_PAY) || out_ready);
  assign out_valid  = (state == S_PAY) && in_valid;
  assign out_data   = in_data;
  assign info_valid = EXPOSE_INFO && (state == S_BODY) && in_valid;
  assign info_data  = in_data;
  assign info_field = fld;
  assign hdr_error  = err_q;
  assign done       = done_q;
  assign len_valid  = len_ok_q;
  assign pay_len    = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_PRE;
      idx      <= '0;
      fld      <= '0;
      sec_hi   <= '0;
      sec_cnt  <= '0;
      len_sh   <= '0;
      rem      <= '0;
      len_q    <= '0;
      len_ok_q <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fire) begin
        case (state)
          S_PRE: begin
            if (in_data != pre_byte(idx)) begin
              state <= S_ERR;
              err_q <= 1'b1;
            end else if (idx == 4'(PRE_LEN - 1)) begin
              state <= S_TAG;
              idx   <= '0;
              fld   <= '0;
            end else begin
              idx <= idx + 4'd1;
            end
          end
          S_TAG: state <= S_LHI;
          S_LHI: begin
            sec_hi <= in_data;
            state  <= S_LLO;
          end
          S_LLO: begin
            if (sec_len == 16'd0) begin
              state <= last_fld ? S_ETAG : S_TAG;
              fld   <= fld + 1'b1;
            end else begin
              sec_cnt <= sec_len;
              state   <= S_BODY;
            end
          end
          S_BODY: begin
            if (sec_cnt == 16'd1) begin
              state <= last_fld ? S_ETAG : S_TAG;
              fld   <= fld + 1'b1;
            end
            sec_cnt <= sec_cnt - 16'd1;
          end
          S_ETAG: begin
            if (in_data != END_TAG) begin
              state <= S_ERR;
              err_q <= 1'b1;
            end else begin
              state <= S_PLEN;
              idx   <= '0;
            end
          end
          S_PLEN: begin
            len_sh <= len_full[23:0];
            if (idx == 4'(LEN_BYTES - 1)) begin
              len_q    <= len_full;
              len_ok_q <= 1'b1;
              rem      <= len_full;
              if (len_full == 32'd0) begin
                state  <= S_FIN;
                done_q <= 1'b1;
              end else begin
                state <= S_PAY;
              end
            end else begin
              idx <= idx + 4'd1;
            end
          end
          S_PAY: begin
            if (rem == 32'd1) begin
              state  <= S_FIN;
              done_q <= 1'b1;
            end
            rem <= rem - 32'd1;
          end
          default: ;
        endcase
      end
    end
  end

  // R2 / R5: error is sticky and blocks input
  a_r2_err_sticky: assert property (@(posedge clk) disable iff (rst)
    hdr_error |=> hdr_error);
  a_r5_err_blocks: assert property (@(posedge clk) disable iff (rst)
    hdr_error |-> (!in_ready && !len_valid && !out_valid));
  // R6: parsed length held
  a_r6_len_hold: assert property (@(posedge clk) disable iff (rst)
    len_valid |=> (len_valid && $stable(pay_len)));
  // R7: payload only after length known, stalls when downstream stalls
  a_r7_pay_after_len: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (len_valid && (in_ready == out_ready)));
  // R8: single-cycle done, then input closed
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !in_ready));
  // R10: text and payload outputs never overlap
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    info_valid |-> (!out_valid && !len_valid));
endmodule

// File: tb/cfg_hdr_parser_tb.sv
module cfg_hdr_parser_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b1;

  logic       in_ready, out_valid, info_valid, hdr_error, done, len_valid;
  logic [7:0] out_data, info_data;
  logic [1:0] info_field;
  logic [31:0] pay_len;

  logic       s_in_ready, s_out_valid, s_info_valid, s_hdr_error, s_done, s_len_valid;
  logic [7:0] s_out_data, s_info_data;
  logic [1:0] s_info_field;
  logic [31:0] s_pay_len;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  cfg_hdr_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .info_valid(info_valid), .info_data(info_data), .info_field(info_field),
    .hdr_error(hdr_error), .done(done), .len_valid(len_valid), .pay_len(pay_len));

  cfg_hdr_parser #(.EXPOSE_INFO(1'b0)) u_skip (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(s_in_ready),
    .out_valid(s_out_valid), .out_data(s_out_data), .out_ready(out_ready),
    .info_valid(s_info_valid), .info_data(s_info_data), .info_field(s_info_field),
    .hdr_error(s_hdr_error), .done(s_done), .len_valid(s_len_valid), .pay_len(s_pay_len));

  // {byte, kind[1:0], field[1:0]}; kind 0 header, 1 text, 2 payload
  localparam logic [11:0] VEC [37] = '{
    12'h000, 12'h090, 12'h0F0, 12'hF00, 12'h0F0, 12'hF00, 12'h0F0, 12'hF00,
    12'h0F0, 12'hF00, 12'h000, 12'h000, 12'h010,
    12'h610, 12'h000, 12'h020, 12'h784, 12'h794,
    12'h620, 12'h000, 12'h000,
    12'h630, 12'h000, 12'h010, 12'h7A6,
    12'h640, 12'h000, 12'h010, 12'h777,
    12'h650, 12'h000, 12'h000, 12'h000, 12'h030,
    12'h118, 12'h228, 12'h338
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic send_hdr(input logic [7:0] etag);
    for (int i = 0; i < 13; i++) push(VEC[i][11:4]);
    for (int s = 0; s < 4; s++) begin
      push(8'h41 + 8'(s)); push(8'h00); push(8'h00);
    end
    push(etag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 hdr_error", hdr_error, 0);
    chk("R1 done", done, 0);
    chk("R1 len_valid", len_valid, 0);
    chk("R1 pay_len", pay_len, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 info_valid", info_valid, 0);

    // table walk: full image, R2 R3 R4 R9 R10 R7
    for (int i = 0; i < 37; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = VEC[i][11:4];
      #1;
      chk("R2 in_ready during image", in_ready, 1);
      chk("R3 R10 info_valid class", info_valid, (VEC[i][3:2] == 2'd1));
      chk("R7 R10 out_valid class", out_valid, (VEC[i][3:2] == 2'd2));
      chk("R9 skip info_valid", s_info_valid, 0);
      chk("R9 skip out_valid", s_out_valid, (VEC[i][3:2] == 2'd2));
      if (VEC[i][3:2] == 2'd1) begin
        chk("R3 info_field", info_field, VEC[i][1:0]);
        chk("R3 info_data", info_data, VEC[i][11:4]);
      end
      if (VEC[i][3:2] == 2'd2) chk("R7 out_data", out_data, VEC[i][11:4]);
      @(posedge clk);
    end
    idle();
    chk("R8 done after last byte", done, 1);
    chk("R6 pay_len", pay_len, 3);
    chk("R6 len_valid", len_valid, 1);
    chk("R9 skip done", s_done, 1);
    idle();
    chk("R8 done single cycle", done, 0);
    chk("R8 in_ready closed", in_ready, 0);
    chk("R6 pay_len held", pay_len, 3);

    // R2: mismatch at signature position 3
    do_reset();
    push(8'h00); push(8'h09); push(8'h0F); push(8'h00);
    idle();
    chk("R2 error set", hdr_error, 1);
    chk("R2 in_ready low", in_ready, 0);
    push(8'hF0); push(8'h0F);
    idle();
    chk("R2 error sticky", hdr_error, 1);
    chk("R2 no length", len_valid, 0);

    // R2: mismatch at last signature byte
    do_reset();
    for (int i = 0; i < 12; i++) push(VEC[i][11:4]);
    idle();
    chk("R2 no error before last", hdr_error, 0);
    push(8'h02);
    idle();
    chk("R2 last byte error", hdr_error, 1);

    // R5: wrong end tag
    do_reset();
    send_hdr(8'h66);
    idle();
    chk("R5 bad end tag error", hdr_error, 1);
    chk("R5 in_ready low", in_ready, 0);

    // R4 R8: zero-length sections and zero payload
    do_reset();
    send_hdr(8'h65);
    idle();
    chk("R4 R5 zero sections ok", hdr_error, 0);
    push(8'h00); push(8'h00); push(8'h00); push(8'h00);
    idle();
    chk("R8 done on zero length", done, 1);
    chk("R6 zero pay_len", pay_len, 0);
    chk("R6 len_valid zero", len_valid, 1);
    idle();
    chk("R8 closed after zero", in_ready, 0);

    // R6: byte order
    do_reset();
    send_hdr(8'h65);
    push(8'h12); push(8'h34); push(8'h56); push(8'h78);
    idle();
    chk("R6 msb first", pay_len, 32'h12345678);
    chk("R8 no early done", done, 0);

    // R7: backpressure
    do_reset();
    send_hdr(8'h65);
    push(8'h00); push(8'h00); push(8'h00); push(8'h02);
    idle();
    chk("R6 len 2", pay_len, 2);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hAB;
    #1;
    chk("R7 stall out_valid", out_valid, 1);
    chk("R7 stall in_ready", in_ready, 0);
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk("R7 resume in_ready", in_ready, 1);
    chk("R7 held byte", out_data, 8'hAB);
    @(posedge clk);
    idle();
    chk("R8 not done after 1 of 2", done, 0);
    push(8'hCD);
    idle();
    chk("R8 done after 2 of 2", done, 1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule